// File: doc/BRIEF.md
# CAN Frame Timestamp Capture Unit

This block keeps a free-running bit-time counter for a CAN controller and stamps each frame with the counter value taken when the frame's identifier field begins on the bus. The stamp is held while the frame is in flight. It is delivered to the message buffer that owns the frame only once the frame's outcome is known. For a reception, that is when the frame is stored into a receive buffer. For a transmission, it is when the transmission completes successfully. A failed transmission leaves no stamp.

The bus decoder drives a one-cycle strobe when the identifier starts, and the buffer logic reports store and completion events with a buffer index. The block answers one cycle later with a write strobe, the stamp value and the target index. An optional synchronization mode clears the counter whenever a frame is received into buffer 0. The write for that frame still carries the stamp taken before the clear. A network master can use this mode to align the time bases of all nodes.

Top module: `can_tstamp_unit`

## Requirements
- R1: After reset the counter output reads 0, the write strobe is low, and no stamp is pending, so a store event with no identifier start before it produces no write.
- R2: The counter advances by exactly one in every cycle in which the tick input is high and holds otherwise. It is 16 bits wide and wraps from 0xFFFF to 0x0000 without any indication.
- R3: In a cycle with the identifier-start strobe high, the pending stamp takes the counter value visible on the counter output in that same cycle. A tick in that cycle only affects the counter from the next cycle on.
- R4: A receive-store event while a stamp is pending raises the write strobe in the next cycle for one cycle, with the pending stamp as value and the receive index as target. The stamp is then no longer pending.
- R5: A transmit-complete event with the success flag high while a stamp is pending raises the write strobe in the next cycle, with the pending stamp as value and the transmit index as target.
- R6: A transmit-complete event with the success flag low writes nothing and discards the pending stamp, so a following store event writes nothing.
- R7: A new identifier-start strobe replaces any pending stamp that has not been written yet.
- R8: With sync mode on, a receive-store event to buffer index 0 makes the counter read 0 in the next cycle, even if the tick is high in the same cycle.
- R9: The stamp written for a buffer-0 reception in sync mode is the value captured at identifier start, not the cleared counter value.
- R10: A store or completion event with no pending stamp produces no write strobe.
- R11: If a receive-store event and a successful transmit-complete event arrive in the same cycle, only the receive is written and the transmit event is dropped.
- R12: With sync mode off, a receive-store event to buffer index 0 leaves the counter running unchanged and still writes the stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Bit-time tick that advances the counter |
| id_start_i | input | 1 | One-cycle strobe at the start of the identifier field |
| rx_store_i | input | 1 | A received frame is being stored into a buffer |
| rx_idx_i | input | 4 | Target buffer index of the reception |
| tx_done_i | input | 1 | A transmission has ended |
| tx_ok_i | input | 1 | The ending transmission succeeded |
| tx_idx_i | input | 4 | Source buffer index of the transmission |
| sync_en_i | input | 1 | Enables counter clear on reception into buffer 0 |
| ts_wr_o | output | 1 | Timestamp write strobe |
| ts_val_o | output | 16 | Timestamp value to write |
| ts_idx_o | output | 4 | Buffer index the timestamp belongs to |
| timer_o | output | 16 | Current counter value |

## Verification
The embedded assertions check on every cycle the counter's step-or-hold rule and its clear in sync mode. They also check that a captured stamp equals the counter value of the start cycle, that a write always follows a qualifying event with a pending stamp and carries that stamp, and that receive wins over transmit. Only the directed scenarios can show the end-to-end sequences: a discarded stamp staying discarded across later events, an overwrite by a second identifier start, the counter wrap after 65536 ticks, and a buffer-0 write carrying the pre-clear value while the counter restarts from zero.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  // Default counter width and buffer count for the unit.
  localparam int unsigned TS_W_DEF = 16;
  localparam int unsigned NBUF_DEF = 16;

  // Which event, if any, commits the pending stamp this cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2
  } commit_src_e;

endpackage

// File: rtl/tstamp_rst_sync.sv
module tstamp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;
  logic         count_en;

  // Next state: clear dominates a tick in the same cycle.
  always_comb begin
    count_en = clr_i | tick_i;
    if (clr_i) begin
      count_d = '0;
    end else begin
      count_d = count_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i) |=> (count_o == $past(count_o) + W'(1))); // R2
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(count_o)); // R2
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0)); // R8

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         id_start_i,
  input  logic [W-1:0] timer_i,
  input  logic         consume_i,
  output logic [W-1:0] cap_o,
  output logic         vld_o
);

  logic [W-1:0] cap_q;
  logic         vld_q;
  logic         vld_d;

  // A fresh identifier start always wins over a consume in the same cycle.
  always_comb begin
    if (id_start_i) begin
      vld_d = 1'b1;
    end else if (consume_i) begin
      vld_d = 1'b0;
    end else begin
      vld_d = vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (id_start_i) begin
      cap_q <= timer_i;
    end
  end

  assign cap_o = cap_q;
  assign vld_o = vld_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    id_start_i |=> (vld_o && cap_o == $past(timer_i))); // R3
  AST_CAPTURE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !id_start_i) |=> !vld_o); // R6
  AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume_i && !id_start_i) |=> ($stable(cap_o) && $stable(vld_o))); // R7

endmodule

// File: rtl/tstamp_commit.sv
module tstamp_commit
  import tstamp_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_store_i,
  input  logic [IW-1:0] rx_idx_i,
  input  logic          tx_done_i,
  input  logic          tx_ok_i,
  input  logic [IW-1:0] tx_idx_i,
  input  logic [W-1:0]  cap_i,
  input  logic          vld_i,
  output logic          consume_o,
  output logic          wr_o,
  output logic [W-1:0]  val_o,
  output logic [IW-1:0] idx_o
);

  commit_src_e   src;
  logic          wr_d;
  logic [IW-1:0] idx_d;
  logic          wr_q;
  logic [W-1:0]  val_q;
  logic [IW-1:0] idx_q;

  // Select the committing event; reception has priority over transmission.
  always_comb begin
    src = SRC_NONE;
    if (rx_store_i && vld_i) begin
      src = SRC_RX;
    end else if (tx_done_i && tx_ok_i && vld_i) begin
      src = SRC_TX;
    end
    wr_d  = (src != SRC_NONE);
    idx_d = (src == SRC_RX) ? rx_idx_i : tx_idx_i;
    // Any end-of-frame event retires the pending stamp, written or not.
    consume_o = rx_store_i | tx_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
    end else begin
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      idx_q <= '0;
    end else if (wr_d) begin
      val_q <= cap_i;
      idx_q <= idx_d;
    end
  end

  assign wr_o  = wr_q;
  assign val_o = val_q;
  assign idx_o = idx_q;

  AST_WR_NEEDS_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> $past(vld_i)); // R10
  AST_WR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (val_o == $past(cap_i))); // R9
  AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_store_i && vld_i) |=> (wr_o && idx_o == $past(rx_idx_i))); // R11
  AST_TX_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_i && !tx_ok_i && !rx_store_i) |=> !wr_o); // R6

endmodule

// File: rtl/can_tstamp_unit.sv
module can_tstamp_unit
  import tstamp_pkg::*;
#(
  parameter int unsigned TS_W = TS_W_DEF,
  parameter int unsigned NBUF = NBUF_DEF,
  localparam int unsigned IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             id_start_i,
  input  logic             rx_store_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic             tx_done_i,
  input  logic             tx_ok_i,
  input  logic [IDX_W-1:0] tx_idx_i,
  input  logic             sync_en_i,
  output logic             ts_wr_o,
  output logic [TS_W-1:0]  ts_val_o,
  output logic [IDX_W-1:0] ts_idx_o,
  output logic [TS_W-1:0]  timer_o
);

  logic            rst_n_int;
  logic            sync_clr;
  logic [TS_W-1:0] timer_val;
  logic [TS_W-1:0] cap_val;
  logic            cap_vld;
  logic            consume;

  tstamp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Network time sync: a reception into buffer 0 restarts the counter.
  assign sync_clr = sync_en_i & rx_store_i & (rx_idx_i == '0);

  tstamp_timer #(.W(TS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick_i  (tick_i),
    .clr_i   (sync_clr),
    .count_o (timer_val)
  );

  tstamp_capture #(.W(TS_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .id_start_i (id_start_i),
    .timer_i    (timer_val),
    .consume_i  (consume),
    .cap_o      (cap_val),
    .vld_o      (cap_vld)
  );

  tstamp_commit #(.W(TS_W), .IW(IDX_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rx_store_i (rx_store_i),
    .rx_idx_i   (rx_idx_i),
    .tx_done_i  (tx_done_i),
    .tx_ok_i    (tx_ok_i),
    .tx_idx_i   (tx_idx_i),
    .cap_i      (cap_val),
    .vld_i      (cap_vld),
    .consume_o  (consume),
    .wr_o       (ts_wr_o),
    .val_o      (ts_val_o),
    .idx_o      (ts_idx_o)
  );

  assign timer_o = timer_val;

  AST_SYNC_OFF_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sync_en_i && tick_i) |=> (timer_o == $past(timer_o) + TS_W'(1))); // R12
  AST_WR_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!rx_store_i && !tx_done_i) |=> !ts_wr_o); // R4

endmodule

// File: tb/tb_can_tstamp_unit.sv
`timescale 1ns/1ps
module tb_can_tstamp_unit;

  localparam int TW = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, id_start = 1'b0, rx_store = 1'b0;
  logic          tx_done = 1'b0, tx_ok = 1'b0, sync_en = 1'b0;
  logic [IW-1:0] rx_idx = '0, tx_idx = '0;
  logic          ts_wr;
  logic [TW-1:0] ts_val, timer;
  logic [IW-1:0] ts_idx;

  int checks = 0;
  int fails = 0;
  logic [TW-1:0] exp_t;
  logic [TW-1:0] stamp;

  always #2 clk = ~clk;

  can_tstamp_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .id_start_i(id_start),
    .rx_store_i(rx_store), .rx_idx_i(rx_idx), .tx_done_i(tx_done),
    .tx_ok_i(tx_ok), .tx_idx_i(tx_idx), .sync_en_i(sync_en),
    .ts_wr_o(ts_wr), .ts_val_o(ts_val), .ts_idx_o(ts_idx), .timer_o(timer)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // One clock; inputs were set just after the previous edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_all();
    tick = 0; id_start = 0; rx_store = 0; tx_done = 0; tx_ok = 0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1;
    for (int i = 0; i < n; i++) cyc();
    tick = 0;
    exp_t = exp_t + TW'(n);
  endtask

  task automatic t_reset();
    chk("R1 timer after reset", timer, 0);
    chk("R1 write strobe after reset", ts_wr, 0);
    rx_store = 1; rx_idx = 4'd3; cyc(); rx_store = 0;
    chk("R1 no pending stamp after reset", ts_wr, 0);
    cyc();
  endtask

  task automatic t_count();
    run_ticks(5);
    chk("R2 count after 5 ticks", timer, exp_t);
    cyc(); cyc(); cyc();
    chk("R2 hold without tick", timer, exp_t);
  endtask

  task automatic t_rx();
    stamp = timer;
    id_start = 1; tick = 1; cyc(); id_start = 0; tick = 0;
    exp_t = exp_t + 1;
    chk("R2 tick alongside id start", timer, exp_t);
    run_ticks(3);
    rx_store = 1; rx_idx = 4'd7; cyc(); rx_store = 0;
    chk("R4 rx write strobe", ts_wr, 1);
    chk("R3 stamp is pre-tick value", ts_val, stamp);
    chk("R4 rx index", ts_idx, 7);
    cyc();
    chk("R4 strobe is one cycle", ts_wr, 0);
    rx_store = 1; rx_idx = 4'd6; cyc(); rx_store = 0;
    chk("R10 consumed stamp not rewritten", ts_wr, 0);
    cyc();
  endtask

  task automatic t_tx();
    run_ticks(2);
    stamp = timer;
    id_start = 1; cyc(); id_start = 0;
    run_ticks(4);
    tx_done = 1; tx_ok = 1; tx_idx = 4'd3; cyc(); tx_done = 0; tx_ok = 0;
    chk("R5 tx write strobe", ts_wr, 1);
    chk("R5 tx value", ts_val, stamp);
    chk("R5 tx index", ts_idx, 3);
    cyc();
  endtask

  task automatic t_txfail();
    id_start = 1; cyc(); id_start = 0;
    run_ticks(2);
    tx_done = 1; tx_ok = 0; tx_idx = 4'd4; cyc(); tx_done = 0;
    chk("R6 failed tx writes nothing", ts_wr, 0);
    rx_store = 1; rx_idx = 4'd2; cyc(); rx_store = 0;
    chk("R6 discarded stamp stays discarded", ts_wr, 0);
    cyc();
  endtask

  task automatic t_overwrite();
    id_start = 1; cyc(); id_start = 0;
    run_ticks(4);
    stamp = timer;
    id_start = 1; cyc(); id_start = 0;
    run_ticks(2);
    rx_store = 1; rx_idx = 4'd9; cyc(); rx_store = 0;
    chk("R7 second start overwrites", ts_val, stamp);
    chk("R7 write happens", ts_wr, 1);
    cyc();
  endtask

  task automatic t_sync();
    sync_en = 1;
    run_ticks(3);
    stamp = timer;
    id_start = 1; cyc(); id_start = 0;
    run_ticks(2);
    rx_store = 1; rx_idx = 4'd0; tick = 1; cyc(); rx_store = 0; tick = 0;
    exp_t = '0;
    chk("R8 counter cleared despite tick", timer, 0);
    chk("R9 buffer0 write strobe", ts_wr, 1);
    chk("R9 buffer0 value is pre-clear", ts_val, stamp);
    chk("R9 buffer0 index", ts_idx, 0);
    run_ticks(1);
    chk("R8 counter restarts", timer, 1);
    sync_en = 0;
    cyc();
  endtask

  task automatic t_nosync();
    sync_en = 0;
    run_ticks(6);
    stamp = timer;
    id_start = 1; cyc(); id_start = 0;
    rx_store = 1; rx_idx = 4'd0; tick = 1; cyc(); rx_store = 0; tick = 0;
    exp_t = exp_t + 1;
    chk("R12 counter keeps running", timer, exp_t);
    chk("R12 stamp still written", ts_wr, 1);
    chk("R12 stamp value", ts_val, stamp);
    cyc();
  endtask

  task automatic t_both();
    stamp = timer;
    id_start = 1; cyc(); id_start = 0;
    rx_store = 1; rx_idx = 4'd5; tx_done = 1; tx_ok = 1; tx_idx = 4'd11;
    cyc();
    idle_all();
    chk("R11 receive written", ts_wr, 1);
    chk("R11 receive index wins", ts_idx, 5);
    chk("R11 value", ts_val, stamp);
    cyc();
    chk("R11 transmit dropped", ts_wr, 0);
  endtask

  task automatic t_wrap();
    sync_en = 1; rx_store = 1; rx_idx = 4'd0; cyc(); rx_store = 0; sync_en = 0;
    exp_t = '0;
    chk("R10 clear with no stamp writes nothing", ts_wr, 0);
    chk("R8 clear with no stamp", timer, 0);
    run_ticks(65535);
    chk("R2 counter at top", timer, 16'hFFFF);
    run_ticks(1);
    chk("R2 counter wraps", timer, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    exp_t = '0;
    stamp = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) cyc();
    t_reset();
    t_count();
    t_rx();
    t_tx();
    t_txfail();
    t_overwrite();
    t_sync();
    t_nosync();
    t_both();
    t_wrap();
    report();
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

endmodule